// File: doc/BRIEF.md
# SPI Pad Direction and Mode-Fault Controller

This block sits between an SPI shift engine and the four SPI pads (MISO, MOSI, SCK, SS). It keeps a small control register and the master/slave role bit. From these it works out, cycle by cycle, which pads are driven, which pad feeds the engine's serial input, and whether SS is ignored, watched as a plain input, watched for mode faults, or driven automatically. Two wiring modes are supported. In four-wire mode data flows out on one pin and in on the other. In single-wire mode one pad carries data in both directions, and which pad that is depends on the role.

A mode fault means that some other master has pulled SS low while this block is a master that watches SS. When that happens the block sets a sticky fault flag and drops every pad output enable in the same cycle. On the next edge it clears the role bit, so the block falls back to slave. The flag stays set until software pulses a clear strobe. A separate output tells the clock generator to stop while the chip is in wait mode, if the register asks for that. The SS pad passes through a synchronizer chain before anything uses it.

Top module: `spi_pinctl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x08, `is_master` is 0 and `fault_flag` is 0.
- R2: A write stores bit 4 (fault detect enable), bit 3 (single-wire drive enable), bit 1 (halt in wait) and bit 0 (single-wire mode select). Bits 7, 6, 5 and 2 always read 0. The read value changes one cycle after the write.
- R3: `ss_oe` is 1 only when bit 4 is 1, `ss_auto_en` is 1 and `is_master` is 1. In slave role SS is never driven, and `ss_o` follows `eng_ss`.
- R4: In four-wire mode (bit 0 = 0) a master drives MOSI (`mosi_oe`=1, `mosi_o`=`eng_sdo`), leaves MISO undriven and feeds `miso_i` to `eng_sdi`. A slave leaves MOSI undriven and feeds `mosi_i` to `eng_sdi`.
- R5: In single-wire mode a master uses MOSI only. `mosi_oe` equals bit 3, `eng_sdi` is `mosi_i` and `miso_oe` is 0.
- R6: In single-wire mode a slave uses MISO only. `miso_oe` is 1 only when bit 3 is 1 and the synchronized SS is low. `eng_sdi` is `miso_i` and `mosi_oe` is 0.
- R7: `sck_oe` is 1 exactly when `is_master` is 1 and no fault is being detected. `sck_o` follows `eng_sck`, and `eng_sck_in` follows `sck_i`.
- R8: A fault is detected when `is_master`=1, bit 4=1, `ss_auto_en`=0 and the synchronized SS is low. The synchronized SS trails `ss_i` by two clock edges. In the detecting cycle every pad output enable is 0. On the next edge `fault_flag` becomes 1 and `is_master` becomes 0; this overrides a role write made in the same cycle.
- R9: While bit 4 is 0, `fault_flag` never rises.
- R10: `fault_flag` stays set until `fault_clr` is pulsed. A fault detected in the same cycle as a clear leaves the flag set.
- R11: `sck_run` is 0 exactly when bit 1 is 1 and `wait_req` is 1.
- R12: In four-wire slave mode `miso_oe` is 1 only while the synchronized SS is low, with `miso_o`=`eng_sdo`. `eng_sel` is the inverse of the synchronized SS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| role_we | input | 1 | Role bit write strobe |
| role_wval | input | 1 | Role value to write (1 = master) |
| ss_auto_en | input | 1 | Allows SS to be driven automatically by a master |
| fault_clr | input | 1 | Clears the fault flag |
| is_master | output | 1 | Current role bit |
| fault_flag | output | 1 | Sticky mode-fault flag |
| wait_req | input | 1 | Chip wait-mode indication |
| sck_run | output | 1 | Serial clock generation enable |
| eng_sdo | input | 1 | Serial data out from the shift engine |
| eng_sck | input | 1 | Serial clock from the clock generator |
| eng_ss | input | 1 | SS level from the engine when in master role |
| eng_sdi | output | 1 | Serial data in to the shift engine |
| eng_sck_in | output | 1 | Pad clock to the engine when in slave role |
| eng_sel | output | 1 | Synchronized slave select, active high |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO pad output |
| miso_oe | output | 1 | MISO pad output enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad output |
| mosi_oe | output | 1 | MOSI pad output enable |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK pad output |
| sck_oe | output | 1 | SCK pad output enable |
| ss_i | input | 1 | SS pad input |
| ss_o | output | 1 | SS pad output |
| ss_oe | output | 1 | SS pad output enable |

## Verification
The bench builds the block with its defaults: a two-stage SS synchronizer and a reset value of 0x08. That fixes the fault latency at two edges from an SS fall to detection, so the model can predict the exact cycle in which the enables drop. Directed phases cover every role and pin-mode pair and the clear/fault collision. A long pseudo-random phase holds SS mostly high, so masters stay up long enough to be faulted, written back and faulted again in every register setting.

// File: rtl/spi_pinctl_pkg.sv
package spi_pinctl_pkg;
  localparam int CFG_W      = 8;
  localparam int BIT_MFEN   = 4;
  localparam int BIT_BIDOE  = 3;
  localparam int BIT_WHALT  = 1;
  localparam int BIT_ONEW   = 0;

  typedef struct packed {
    logic mf_en;     // fault detect enable
    logic bid_oe;    // single-wire drive enable
    logic w_halt;    // halt clock in wait
    logic one_wire;  // single-wire pin mode
  } cfg_t;

  function automatic logic [CFG_W-1:0] cfg_pack(cfg_t c);
    logic [CFG_W-1:0] v;
    v = '0;
    v[BIT_MFEN]  = c.mf_en;
    v[BIT_BIDOE] = c.bid_oe;
    v[BIT_WHALT] = c.w_halt;
    v[BIT_ONEW]  = c.one_wire;
    return v;
  endfunction

  function automatic cfg_t cfg_unpack(logic [CFG_W-1:0] v);
    cfg_t c;
    c.mf_en    = v[BIT_MFEN];
    c.bid_oe   = v[BIT_BIDOE];
    c.w_halt   = v[BIT_WHALT];
    c.one_wire = v[BIT_ONEW];
    return c;
  endfunction
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  // SS is active low: reset to the idle (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/spi_ctl_state.sv
module spi_ctl_state
  import spi_pinctl_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             role_we,
  input  logic             role_wval,
  input  logic             ss_auto_en,
  input  logic             fault_clr,
  input  logic             ss_sync,
  output cfg_t             cfg,
  output logic             master,
  output logic             fault_now,
  output logic             flag
);
  cfg_t cfg_q, cfg_d;
  logic master_q, master_d;
  logic flag_q, flag_d;

  assign fault_now = master_q & cfg_q.mf_en & ~ss_auto_en & ~ss_sync;

  always_comb begin
    cfg_d    = cfg_q;
    master_d = master_q;
    flag_d   = flag_q;
    if (cfg_we)    cfg_d = cfg_unpack(cfg_wdata);
    if (fault_now) master_d = 1'b0;
    else if (role_we) master_d = role_wval;
    if (fault_now) flag_d = 1'b1;
    else if (fault_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= cfg_unpack(CFG_RESET);
      master_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      master_q <= master_d;
      flag_q   <= flag_d;
    end
  end

  assign cfg    = cfg_q;
  assign master = master_q;
  assign flag   = flag_q;

  AST_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> (!master_q && flag_q)); // R8
  AST_NO_FAULT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.mf_en |=> !$rose(flag_q)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !fault_clr) |=> flag_q); // R10
endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route
  import spi_pinctl_pkg::*;
(
  input  cfg_t cfg,
  input  logic master,
  input  logic fault_now,
  input  logic ss_auto_en,
  input  logic ss_sync,
  input  logic eng_sdo,
  input  logic eng_sck,
  input  logic eng_ss,
  input  logic miso_i,
  input  logic mosi_i,
  input  logic sck_i,
  output logic eng_sdi,
  output logic eng_sck_in,
  output logic eng_sel,
  output logic miso_o,
  output logic miso_oe,
  output logic mosi_o,
  output logic mosi_oe,
  output logic sck_o,
  output logic sck_oe,
  output logic ss_o,
  output logic ss_oe
);
  logic keep;
  logic miso_raw, mosi_raw;

  assign keep = ~fault_now;

  always_comb begin
    miso_raw = 1'b0;
    mosi_raw = 1'b0;
    eng_sdi  = 1'b0;
    unique case ({master, cfg.one_wire})
      2'b10: begin mosi_raw = 1'b1;           eng_sdi = miso_i; end
      2'b11: begin mosi_raw = cfg.bid_oe;     eng_sdi = mosi_i; end
      2'b00: begin miso_raw = ~ss_sync;       eng_sdi = mosi_i; end
      default: begin miso_raw = cfg.bid_oe & ~ss_sync; eng_sdi = miso_i; end
    endcase
  end

  assign miso_oe    = miso_raw & keep;
  assign mosi_oe    = mosi_raw & keep;
  assign sck_oe     = master & keep;
  assign ss_oe      = cfg.mf_en & ss_auto_en & master & keep;
  assign miso_o     = eng_sdo;
  assign mosi_o     = eng_sdo;
  assign sck_o      = eng_sck;
  assign ss_o       = eng_ss;
  assign eng_sck_in = sck_i;
  assign eng_sel    = ~ss_sync;

  always_comb begin
    AST_SLAVE_NO_MOSI: assert (master || !mosi_oe); // R6
    AST_MASTER_NO_MISO: assert (!master || !miso_oe); // R5
  end
endmodule

// File: rtl/spi_pinctl.sv
module spi_pinctl
  import spi_pinctl_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0] CFG_RESET   = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             role_we,
  input  logic             role_wval,
  input  logic             ss_auto_en,
  input  logic             fault_clr,
  output logic             is_master,
  output logic             fault_flag,
  input  logic             wait_req,
  output logic             sck_run,
  input  logic             eng_sdo,
  input  logic             eng_sck,
  input  logic             eng_ss,
  output logic             eng_sdi,
  output logic             eng_sck_in,
  output logic             eng_sel,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             ss_i,
  output logic             ss_o,
  output logic             ss_oe
);
  cfg_t cfg;
  logic ss_sync, fault_now;

  spi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_i), .q(ss_sync)
  );

  spi_ctl_state #(.CFG_RESET(CFG_RESET)) u_state (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .role_we(role_we), .role_wval(role_wval), .ss_auto_en(ss_auto_en),
    .fault_clr(fault_clr), .ss_sync(ss_sync), .cfg(cfg),
    .master(is_master), .fault_now(fault_now), .flag(fault_flag)
  );

  spi_pin_route u_route (
    .cfg(cfg), .master(is_master), .fault_now(fault_now),
    .ss_auto_en(ss_auto_en), .ss_sync(ss_sync),
    .eng_sdo(eng_sdo), .eng_sck(eng_sck), .eng_ss(eng_ss),
    .miso_i(miso_i), .mosi_i(mosi_i), .sck_i(sck_i),
    .eng_sdi(eng_sdi), .eng_sck_in(eng_sck_in), .eng_sel(eng_sel),
    .miso_o(miso_o), .miso_oe(miso_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .sck_o(sck_o), .sck_oe(sck_oe), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  assign cfg_rdata = cfg_pack(cfg);
  assign sck_run   = ~(cfg.w_halt & wait_req);

  AST_SS_OE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    ss_oe |-> (is_master && ss_auto_en && cfg_rdata[BIT_MFEN])); // R3
  AST_SCK_OE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    sck_oe |-> is_master); // R7
  AST_WAIT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && cfg_rdata[BIT_WHALT]) |-> !sck_run); // R11
  AST_SLAVE_MISO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && !is_master) |-> eng_sel); // R12
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:5] == 3'b000) && !cfg_rdata[2]); // R2
endmodule

// File: tb/sim_spi_pinctl.sv
module sim_spi_pinctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cfg_we = 0, role_we = 0, role_wval = 0, ss_auto_en = 0, fault_clr = 0;
  logic [7:0] cfg_wdata = 0;
  logic       wait_req = 0, eng_sdo = 0, eng_sck = 0, eng_ss = 0;
  logic       miso_i = 0, mosi_i = 0, sck_i = 0, ss_i = 1;
  logic [7:0] cfg_rdata;
  logic is_master, fault_flag, sck_run, eng_sdi, eng_sck_in, eng_sel;
  logic miso_o, miso_oe, mosi_o, mosi_oe, sck_o, sck_oe, ss_o, ss_oe;

  spi_pinctl u0 (.*);

  int vecs = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic m_mf, m_bo, m_wh, m_ow, m_mst, m_flg, m_s1, m_s2;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mreset();
    m_mf = 0; m_bo = 1; m_wh = 0; m_ow = 0; m_mst = 0; m_flg = 0; m_s1 = 1; m_s2 = 1;
  endtask

  task automatic compare_all();
    logic fn, ok, e_mi, e_mo, e_sdi;
    fn = m_mst & m_mf & ~ss_auto_en & ~m_s2;
    ok = ~fn;
    e_mi = 0; e_mo = 0;
    if (m_mst) begin
      e_mo  = (m_ow ? m_bo : 1'b1) & ok;
      e_sdi = m_ow ? mosi_i : miso_i;
    end else begin
      e_mi  = (m_ow ? m_bo : 1'b1) & ~m_s2;
      e_sdi = m_ow ? miso_i : mosi_i;
    end
    chk("R2 cfg_rdata", cfg_rdata, {3'b0, m_mf, m_bo, 1'b0, m_wh, m_ow});
    chk("R8 is_master", {7'b0, is_master}, {7'b0, m_mst});
    chk("R10 fault_flag", {7'b0, fault_flag}, {7'b0, m_flg});
    chk("R3 ss_oe/ss_o", {6'b0, ss_oe, ss_o}, {6'b0, m_mf & ss_auto_en & m_mst & ok, eng_ss});
    chk("R7 sck pins", {5'b0, sck_oe, sck_o, eng_sck_in}, {5'b0, m_mst & ok, eng_sck, sck_i});
    chk("R11 sck_run", {7'b0, sck_run}, {7'b0, ~(m_wh & wait_req)});
    if (m_mst)
      chk(m_ow ? "R5 master 1-wire pins" : "R4 master 4-wire pins",
          {3'b0, miso_oe, mosi_oe, mosi_o, miso_o, eng_sdi},
          {3'b0, 1'b0, e_mo, eng_sdo, eng_sdo, e_sdi});
    else
      chk(m_ow ? "R6 slave 1-wire pins" : "R12 slave 4-wire pins",
          {2'b0, eng_sel, miso_oe, mosi_oe, mosi_o, miso_o, eng_sdi},
          {2'b0, ~m_s2, e_mi, 1'b0, eng_sdo, eng_sdo, e_sdi});
  endtask

  task automatic mstep();
    logic fn;
    fn = m_mst & m_mf & ~ss_auto_en & ~m_s2;
    if (cfg_we) begin
      m_mf = cfg_wdata[4]; m_bo = cfg_wdata[3]; m_wh = cfg_wdata[1]; m_ow = cfg_wdata[0];
    end
    if (fn) m_mst = 0; else if (role_we) m_mst = role_wval;
    if (fn) m_flg = 1; else if (fault_clr) m_flg = 0;
    m_s2 = m_s1; m_s1 = ss_i;
  endtask

  // inputs already set (after a negedge); check, then clock
  task automatic cyc();
    #1 compare_all();
    @(posedge clk);
    mstep();
    @(negedge clk);
    cfg_we = 0; role_we = 0; fault_clr = 0;
  endtask

  task automatic wcfg(logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; cyc();
  endtask

  task automatic wrole(logic v);
    role_we = 1; role_wval = v; cyc();
  endtask

  initial begin
    mreset();
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 reset cfg_rdata", cfg_rdata, 8'h08);
    chk("R1 reset is_master", {7'b0, is_master}, 8'h00);
    chk("R1 reset fault_flag", {7'b0, fault_flag}, 8'h00);
    rst_n = 1;
    cyc();
    // R2 reserved bits masked
    wcfg(8'hFF); cyc();
    chk("R2 readback FF", cfg_rdata, 8'h1B);
    wcfg(8'h00); cyc();
    // R4 four-wire master, R12 four-wire slave with SS toggling
    wrole(1);
    for (int i = 0; i < 8; i++) begin eng_sdo = i[0]; miso_i = i[1]; mosi_i = i[2]; cyc(); end
    wrole(0);
    for (int i = 0; i < 8; i++) begin ss_i = i[1]; eng_sdo = i[0]; mosi_i = i[2]; cyc(); end
    // R6 single-wire slave, drive enable on/off
    ss_i = 0; wcfg(8'h09);
    for (int i = 0; i < 4; i++) begin miso_i = i[0]; cyc(); end
    wcfg(8'h01); cyc(); cyc();
    // R5 single-wire master
    ss_i = 1; cyc(); cyc();
    wrole(1); wcfg(8'h09); cyc(); wcfg(8'h01); cyc();
    // R3 auto SS output
    ss_auto_en = 1; wcfg(8'h10); cyc(); eng_ss = 1; cyc();
    chk("R3 ss_oe auto", {7'b0, ss_oe}, 8'h01);
    // R9 no fault when detection disabled
    ss_auto_en = 0; wcfg(8'h00); ss_i = 0;
    for (int i = 0; i < 6; i++) cyc();
    chk("R9 no fault with enable off", {7'b0, fault_flag}, 8'h00);
    // R8 fault: enable detection, SS already low in synchronizer
    cfg_we = 1; cfg_wdata = 8'h10; cyc();
    #1 chk("R8 oe drop same cycle", {5'b0, mosi_oe, sck_oe, ss_oe}, 8'h00);
    role_we = 1; role_wval = 1; cyc();   // role write loses to fault
    chk("R8 demoted", {6'b0, is_master, fault_flag}, 8'h01);
    // R10 sticky, then collision of clear and new fault
    ss_i = 1; cyc(); cyc(); cyc();
    chk("R10 sticky", {7'b0, fault_flag}, 8'h01);
    wrole(1); ss_i = 0; cyc(); cyc();
    fault_clr = 1; cyc();
    chk("R10 set beats clear", {7'b0, fault_flag}, 8'h01);
    ss_i = 1; cyc(); cyc(); fault_clr = 1; cyc();
    chk("R10 cleared", {7'b0, fault_flag}, 8'h00);
    // R11 wait halt
    wcfg(8'h02); wait_req = 1; cyc(); wait_req = 0; cyc();
    // random phase
    for (int n = 0; n < 6000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cfg_we     = (lfsr[3:0] == 4'h0);
      cfg_wdata  = {lfsr[11:4]};
      role_we    = (lfsr[7:5] == 3'b000);
      role_wval  = lfsr[12];
      ss_auto_en = lfsr[15] & lfsr[2];
      fault_clr  = (lfsr[9:6] == 4'hF);
      wait_req   = lfsr[13];
      ss_i       = (lfsr[14:12] != 3'b000);
      eng_sdo = lfsr[1]; eng_sck = lfsr[4]; eng_ss = lfsr[8];
      miso_i = lfsr[10]; mosi_i = lfsr[11]; sck_i = lfsr[0];
      cyc();
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule